// File: doc/BRIEF.md
# Multi-Lane SPI Master Shift Engine

This block is the shifting core of an SPI master. It moves data over one, two or four data lanes on each shift clock. The transmit side has a single-entry holding buffer. Each word written to it carries a length of 1 to `DW` bits and an end-of-frame flag. The engine loads the word into a shift register and generates the shift clock from the system clock through a programmable divider. It drives the data lanes, samples the incoming lanes and controls the active-low chip select, which covers one or more words that together form a frame.

Frames can be closed in two ways. In fixed mode the frame ends once a programmed bit count (up to 63) has been shifted. In flexible mode the frame has no size limit and closes after the word that carries the end-of-frame flag. A transfer gate can hold a pending word until an external trigger is active.

Every received word goes into a receive buffer that has a valid flag. A normal read clears the flag. A debug read returns the same data and leaves the flag alone. Single-cycle event pulses report each stage of a transfer.

Top module: `spi_lane_shifter`

## Requirements
- R1: `lane_mode` is sampled when a word is loaded. The value 1 selects two lanes, 2 selects four lanes, and 0 or 3 select one lane. Groups go out most significant first. Within a group, the higher lane index carries the more significant bit and lane 0 carries the least. In one-lane mode, only lane 0 is used in each direction. Unused output lanes are driven 0.
- R2: A word has `tx_len`+1 bits (its low bits of `tx_data`). It takes ceil(len/lanes) shift steps. The pad positions after the last data bit are driven 0. Pad bits that arrive on the input lanes are dropped, and the received word is right-aligned.
- R3: The shift clock is low whenever chip select is inactive. Each clock level lasts `clk_div`+1 system cycles. Data lanes change only while the shift clock is low, and inputs are captured when it rises.
- R4: In fixed mode (`frame_fixed`=1), the frame closes at the end of the word whose completion brings the accumulated word bits of the frame to at least `frame_len`. At that point `cs_n` goes high and stays high for at least one half period.
- R5: In flexible mode, `cs_n` stays low between words and goes high only when a word flagged end-of-frame completes.
- R6: When `gate_en`=1, a buffered word does not start while `trig_in`=0. It starts once `trig_in` is 1.
- R7: `tx_ready` is 1 when the holding buffer is empty. `ev_tx_buf` pulses when the buffered word moves into the shifter. `ev_tx_shift` pulses when the last step of a word has completed.
- R8: `ev_rx_start` pulses when a word begins to shift. At word completion, exactly one of two pulses fires: `ev_rx_alt` for the first word of a frame, or `ev_rx` for any later word.
- R9: `ev_data_lost` pulses when a word completes while the receive buffer still holds an unread word. The new word replaces the old one.
- R10: A one-cycle `rx_rd` returns the buffer on `rd_data` in the next cycle and clears `rx_valid`. `dbg_rd` returns the same data and leaves `rx_valid` unchanged.
- R11: After reset, `cs_n`=1, `sclk`=0, `mosi`=0, `tx_ready`=1, `rx_valid`=0, and all event pulses are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lane_mode | input | 2 | Lane count select (sampled per word) |
| frame_fixed | input | 1 | 1: fixed bit-count frames, 0: end-of-frame flag closes frames |
| frame_len | input | FLW | Fixed frame length in bits |
| clk_div | input | DIVW | Half-period of the shift clock minus one, in system cycles |
| gate_en | input | 1 | Enable the transfer trigger gate |
| trig_in | input | 1 | External transfer trigger |
| tx_valid | input | 1 | Write a word into the holding buffer |
| tx_data | input | DW | Transmit word, right-aligned |
| tx_len | input | LW | Word length minus one |
| tx_eof | input | 1 | Word closes the frame (flexible mode) |
| tx_ready | output | 1 | Holding buffer empty |
| sclk | output | 1 | Shift clock, idle low |
| cs_n | output | 1 | Chip select, active low |
| mosi | output | 4 | Outgoing data lanes |
| miso | input | 4 | Incoming data lanes |
| rx_rd | input | 1 | Normal receive read (clears valid) |
| dbg_rd | input | 1 | Debug receive read (no side effect) |
| rd_data | output | DW | Data returned by either read |
| rx_valid | output | 1 | Receive buffer holds an unread word |
| ev_tx_shift | output | 1 | Word has left the shifter |
| ev_tx_buf | output | 1 | Holding buffer emptied |
| ev_rx | output | 1 | Receive completion, not first of frame |
| ev_rx_start | output | 1 | Word began shifting |
| ev_rx_alt | output | 1 | Receive completion, first of frame |
| ev_data_lost | output | 1 | Unread word overwritten |

## Verification
The bench goes after word lengths that are not multiples of the lane count. If the padding were placed at the wrong end, the output would show shifted data, and the input pad bits would show up in the low bits of the received word. It checks fixed frames whose bit count is crossed partway through a word and flexible frames that span several words. An off-by-one frame counter would release chip select one word early or late. It also covers the held trigger, overwriting an unread word and debug reads. A gate that is ignored starts the word early. A debug read that is wired to the normal read path drops `rx_valid`.

// File: rtl/spi_lane_shifter.sv
`timescale 1ns/1ps
module spi_lane_shifter #(
  parameter int DW   = 16,
  parameter int DIVW = 8,
  parameter int FLW  = 6,
  localparam int LW  = $clog2(DW),
  localparam int FCW = FLW + LW + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      lane_mode,
  input  logic            frame_fixed,
  input  logic [FLW-1:0]  frame_len,
  input  logic [DIVW-1:0] clk_div,
  input  logic            gate_en,
  input  logic            trig_in,
  input  logic            tx_valid,
  input  logic [DW-1:0]   tx_data,
  input  logic [LW-1:0]   tx_len,
  input  logic            tx_eof,
  output logic            tx_ready,
  output logic            sclk,
  output logic            cs_n,
  output logic [3:0]      mosi,
  input  logic [3:0]      miso,
  input  logic            rx_rd,
  input  logic            dbg_rd,
  output logic [DW-1:0]   rd_data,
  output logic            rx_valid,
  output logic            ev_tx_shift,
  output logic            ev_tx_buf,
  output logic            ev_rx,
  output logic            ev_rx_start,
  output logic            ev_rx_alt,
  output logic            ev_data_lost
);

  logic            tb_full, tb_eof;
  logic [DW-1:0]   tb_data;
  logic [LW-1:0]   tb_len;
  logic            wact, sclk_q, cs_q, gap, first_w, w_eof, rv;
  logic [DIVW-1:0] div_cnt;
  logic [DW-1:0]   sh_tx, sh_rx, rbuf, rd_q, rx_word;
  logic [1:0]      lsh_q, lsh_n;
  logic [2:0]      lanes_q;
  logic [LW:0]     wlen_q, pad_q, steps_left;
  logic [LW:0]     wlen_n, steps_n, pad_n, shamt_n;
  logic [FCW-1:0]  fcnt, fsum;
  logic [3:0]      g_in, g_out;
  logic            tick, load, rise, fall, done, fend;

  assign tick    = (div_cnt == clk_div);
  assign load    = !wact && !gap && tb_full && (!gate_en || trig_in);
  assign rise    = wact && tick && !sclk_q;
  assign fall    = wact && tick && sclk_q;
  assign done    = fall && (steps_left == (LW+1)'(1));
  assign lanes_q = 3'd1 << lsh_q;

  assign wlen_n  = {1'b0, tb_len} + (LW+1)'(1);
  assign steps_n = (wlen_n + ((LW+1)'(1) << lsh_n) - (LW+1)'(1)) >> lsh_n;
  assign pad_n   = (steps_n << lsh_n) - wlen_n;
  assign shamt_n = (LW+1)'(DW) - wlen_n;
  assign fsum    = fcnt + FCW'(wlen_q);
  assign fend    = frame_fixed ? (fsum >= FCW'(frame_len)) : w_eof;
  assign rx_word = sh_rx >> pad_q;

  always_comb begin
    case (lane_mode)
      2'd1:    lsh_n = 2'd1;
      2'd2:    lsh_n = 2'd2;
      default: lsh_n = 2'd0;
    endcase
  end

  always_comb begin
    case (lsh_q)
      2'd1: begin
        g_in  = {2'b00, miso[1:0]};
        g_out = {2'b00, sh_tx[DW-1 -: 2]};
      end
      2'd2: begin
        g_in  = miso;
        g_out = sh_tx[DW-1 -: 4];
      end
      default: begin
        g_in  = {3'b000, miso[0]};
        g_out = {3'b000, sh_tx[DW-1]};
      end
    endcase
  end

  assign mosi     = wact ? g_out : 4'b0000;
  assign sclk     = sclk_q;
  assign cs_n     = cs_q;
  assign tx_ready = !tb_full;
  assign rx_valid = rv;
  assign rd_data  = rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      div_cnt <= '0;
    else if (load || tick || !(wact || gap))
      div_cnt <= '0;
    else
      div_cnt <= div_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tb_full <= 1'b0;
      tb_eof  <= 1'b0;
      tb_data <= '0;
      tb_len  <= '0;
    end else if (load) begin
      tb_full <= 1'b0;
    end else if (tx_valid && !tb_full) begin
      tb_full <= 1'b1;
      tb_data <= tx_data;
      tb_len  <= tx_len;
      tb_eof  <= tx_eof;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wact        <= 1'b0;
      sclk_q      <= 1'b0;
      cs_q        <= 1'b1;
      gap         <= 1'b0;
      first_w     <= 1'b1;
      w_eof       <= 1'b0;
      sh_tx       <= '0;
      sh_rx       <= '0;
      lsh_q       <= '0;
      wlen_q      <= '0;
      pad_q       <= '0;
      steps_left  <= '0;
      fcnt        <= '0;
      ev_tx_shift <= 1'b0;
      ev_tx_buf   <= 1'b0;
      ev_rx_start <= 1'b0;
    end else begin
      ev_tx_shift <= 1'b0;
      ev_tx_buf   <= 1'b0;
      ev_rx_start <= 1'b0;
      if (gap && tick && !wact)
        gap <= 1'b0;
      if (load) begin
        wact        <= 1'b1;
        cs_q        <= 1'b0;
        sh_tx       <= tb_data << shamt_n;
        sh_rx       <= '0;
        lsh_q       <= lsh_n;
        wlen_q      <= wlen_n;
        pad_q       <= pad_n;
        steps_left  <= steps_n;
        w_eof       <= tb_eof;
        ev_tx_buf   <= 1'b1;
        ev_rx_start <= 1'b1;
      end else if (rise) begin
        sclk_q <= 1'b1;
        sh_rx  <= (sh_rx << lanes_q) | DW'(g_in);
      end else if (fall) begin
        sclk_q <= 1'b0;
        if (done) begin
          wact        <= 1'b0;
          sh_tx       <= '0;
          ev_tx_shift <= 1'b1;
          if (fend) begin
            cs_q    <= 1'b1;
            gap     <= 1'b1;
            fcnt    <= '0;
            first_w <= 1'b1;
          end else begin
            fcnt    <= fsum;
            first_w <= 1'b0;
          end
        end else begin
          steps_left <= steps_left - 1'b1;
          sh_tx      <= sh_tx << lanes_q;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbuf         <= '0;
      rv           <= 1'b0;
      rd_q         <= '0;
      ev_rx        <= 1'b0;
      ev_rx_alt    <= 1'b0;
      ev_data_lost <= 1'b0;
    end else begin
      ev_rx        <= done && !first_w;
      ev_rx_alt    <= done && first_w;
      ev_data_lost <= done && rv && !rx_rd;
      if (rx_rd || dbg_rd)
        rd_q <= rbuf;
      if (done) begin
        rbuf <= rx_word;
        rv   <= 1'b1;
      end else if (rx_rd) begin
        rv   <= 1'b0;
      end
    end
  end

  AST_SCLK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk); // R3
  AST_MOSI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(mosi)); // R3
  AST_GATED_START: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rx_start |-> $past(!gate_en || trig_in)); // R6
  AST_TXBUF_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    ev_tx_buf |-> tx_ready); // R7
  AST_RX_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_rx && ev_rx_alt)); // R8
  AST_LOST_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    ev_data_lost |-> (rx_valid && $past(rx_valid))); // R9
  AST_DBG_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(dbg_rd) && !$past(rx_rd) && $past(rx_valid)) |-> rx_valid); // R10

endmodule

// File: tb/spi_lane_shifter_test.sv
`timescale 1ns/1ps
module spi_lane_shifter_test;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic [1:0]  lane_mode = 2'd0;
  logic        frame_fixed = 1'b0;
  logic [5:0]  frame_len = 6'd8;
  logic [7:0]  clk_div = 8'd1;
  logic        gate_en = 1'b0, trig_in = 1'b0;
  logic        tx_valid = 1'b0, tx_eof = 1'b0;
  logic [15:0] tx_data = '0;
  logic [3:0]  tx_len = '0;
  logic        tx_ready, sclk, cs_n, rx_valid;
  logic [3:0]  mosi, miso;
  logic        rx_rd = 1'b0, dbg_rd = 1'b0;
  logic [15:0] rd_data;
  logic        ev_tx_shift, ev_tx_buf, ev_rx, ev_rx_start, ev_rx_alt, ev_data_lost;

  int checks = 0, fails = 0;
  int mon_n = 0;
  logic [3:0] mon_out [16];
  logic [3:0] mon_in  [16];
  int cnt_rs, cnt_tb, cnt_rx, cnt_alt, cnt_lost, cnt_hi;
  bit exp_first = 1'b1, pend = 1'b0;
  int acc = 0;
  logic [15:0] last_rx_exp;

  spi_lane_shifter uut (
    .clk(clk), .rst_n(rst_n), .lane_mode(lane_mode), .frame_fixed(frame_fixed),
    .frame_len(frame_len), .clk_div(clk_div), .gate_en(gate_en), .trig_in(trig_in),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_len(tx_len), .tx_eof(tx_eof),
    .tx_ready(tx_ready), .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso),
    .rx_rd(rx_rd), .dbg_rd(dbg_rd), .rd_data(rd_data), .rx_valid(rx_valid),
    .ev_tx_shift(ev_tx_shift), .ev_tx_buf(ev_tx_buf), .ev_rx(ev_rx),
    .ev_rx_start(ev_rx_start), .ev_rx_alt(ev_rx_alt), .ev_data_lost(ev_data_lost));

  always #10 clk = ~clk;

  initial begin
    miso = 4'($urandom(32'h5A17));
    forever begin
      @(negedge sclk);
      #1 miso = 4'($urandom);
    end
  end

  initial begin
    forever begin
      @(posedge sclk);
      if (mon_n < 16) begin
        mon_out[mon_n] = mosi;
        mon_in[mon_n]  = miso;
      end
      mon_n++;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int lanes_of(input logic [1:0] m);
    return (m == 2'd1) ? 2 : (m == 2'd2) ? 4 : 1;
  endfunction

  task automatic put_word(input logic [15:0] d, input int len, input bit eof);
    mon_n = 0; cnt_rs = 0; cnt_tb = 0; cnt_rx = 0; cnt_alt = 0; cnt_lost = 0; cnt_hi = 0;
    @(negedge clk);
    while (!tx_ready) @(negedge clk);
    tx_data = d; tx_len = 4'(len - 1); tx_eof = eof; tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic finish_word(input logic [15:0] d, input int len, input bit eof, input bit rd);
    bit seen = 1'b0;
    bit fend;
    int k, steps, bad, ba, be, n;
    logic [3:0] e4;
    logic [15:0] rxw;
    while (!seen) begin
      @(negedge clk);
      if (sclk) cnt_hi++;
      cnt_rs += int'(ev_rx_start); cnt_tb += int'(ev_tx_buf);
      cnt_rx += int'(ev_rx); cnt_alt += int'(ev_rx_alt); cnt_lost += int'(ev_data_lost);
      seen = ev_tx_shift;
    end
    k = lanes_of(lane_mode);
    steps = (len + k - 1) / k;
    chk(mon_n == steps, "R2 step count", mon_n, steps);
    bad = 0; ba = 0; be = 0;
    for (int s = 0; s < steps && s < 16; s++) begin
      e4 = 4'b0000;
      for (int j = 0; j < k; j++) begin
        n = len - 1 - (s * k + (k - 1 - j));
        if (n >= 0) e4[j] = d[n];
      end
      if (mon_out[s] !== e4) begin
        if (bad == 0) begin ba = int'(mon_out[s]); be = int'(e4); end
        bad++;
      end
    end
    chk(bad == 0, "R1 lane groups", ba, be);
    chk(cnt_hi == steps * (int'(clk_div) + 1), "R3 high time", cnt_hi, steps * (int'(clk_div) + 1));
    chk(cnt_rs == 1 && cnt_tb == 1, "R7 start/buffer events", cnt_rs * 16 + cnt_tb, 17);
    chk(cnt_alt == int'(exp_first) && cnt_rx == int'(!exp_first), "R8 receive event kind",
        cnt_alt * 16 + cnt_rx, exp_first ? 16 : 1);
    chk(cnt_lost == int'(pend), "R9 data lost", cnt_lost, int'(pend));
    rxw = '0;
    for (int b = len - 1; b >= 0; b--) begin
      n = len - 1 - b;
      rxw[b] = mon_in[n / k][k - 1 - (n % k)];
    end
    last_rx_exp = rxw;
    pend = 1'b1;
    fend = frame_fixed ? (acc + len >= int'(frame_len)) : eof;
    if (frame_fixed) chk(cs_n == fend, "R4 fixed frame close", int'(cs_n), int'(fend));
    else             chk(cs_n == fend, "R5 flexible frame close", int'(cs_n), int'(fend));
    if (fend) begin acc = 0; exp_first = 1'b1; end
    else begin acc += len; exp_first = 1'b0; end
    if (rd) begin
      @(negedge clk); rx_rd = 1'b1;
      @(negedge clk); rx_rd = 1'b0;
      chk(rd_data == rxw, "R2 received word", int'(rd_data), int'(rxw));
      chk(rx_valid == 1'b0, "R10 normal read clears", int'(rx_valid), 0);
      pend = 1'b0;
    end
  endtask

  task automatic word(input logic [15:0] d, input int len, input bit eof, input bit rd);
    put_word(d, len, eof);
    finish_word(d, len, eof, rd);
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R7 watchdog actual=timeout expected=completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(cs_n == 1'b1 && sclk == 1'b0 && mosi == 4'b0, "R11 reset pins", {cs_n, sclk, mosi}, 6'h20);
    chk(tx_ready == 1'b1 && rx_valid == 1'b0, "R11 reset flags", {tx_ready, rx_valid}, 2);
    chk({ev_tx_shift, ev_tx_buf, ev_rx, ev_rx_start, ev_rx_alt, ev_data_lost} == 6'b0,
        "R11 reset events", 0, 0);
    rst_n = 1'b1;
    @(negedge clk);

    lane_mode = 2'd0; clk_div = 8'd1;
    word(16'hA53C, 16, 1'b1, 1'b1);
    lane_mode = 2'd2;
    word(16'h001B, 5, 1'b1, 1'b1);
    lane_mode = 2'd1;
    word(16'h0005, 3, 1'b0, 1'b1);
    word(16'h005A, 7, 1'b1, 1'b1);

    frame_fixed = 1'b1; frame_len = 6'd20; lane_mode = 2'd0; clk_div = 8'd0;
    word(16'h00C3, 8, 1'b0, 1'b1);
    word(16'h0081, 8, 1'b0, 1'b1);
    word(16'h00FF, 8, 1'b0, 1'b1);
    frame_fixed = 1'b0;

    gate_en = 1'b1; trig_in = 1'b0; lane_mode = 2'd2;
    put_word(16'h1234, 16, 1'b1);
    repeat (40) @(negedge clk);
    chk(cs_n == 1'b1 && tx_ready == 1'b0, "R6 gate holds word", {cs_n, tx_ready}, 2);
    trig_in = 1'b1;
    finish_word(16'h1234, 16, 1'b1, 1'b1);
    gate_en = 1'b0; trig_in = 1'b0;

    word(16'h0F0F, 12, 1'b1, 1'b0);
    word(16'h7E01, 15, 1'b1, 1'b1);

    word(16'h3C3C, 14, 1'b1, 1'b0);
    @(negedge clk); dbg_rd = 1'b1;
    @(negedge clk); dbg_rd = 1'b0;
    chk(rd_data == last_rx_exp, "R10 debug read data", int'(rd_data), int'(last_rx_exp));
    chk(rx_valid == 1'b1, "R10 debug read keeps valid", int'(rx_valid), 1);
    @(negedge clk); rx_rd = 1'b1;
    @(negedge clk); rx_rd = 1'b0;
    chk(rx_valid == 1'b0, "R10 normal read clears", int'(rx_valid), 0);
    pend = 1'b0;

    for (int i = 0; i < 40; i++) begin
      logic [15:0] d;
      int len;
      bit eof, rd;
      if (exp_first) begin
        frame_fixed = 1'($urandom % 2);
        frame_len   = 6'(1 + $urandom % 63);
        clk_div     = 8'($urandom % 4);
      end
      lane_mode = 2'($urandom % 4);
      len = 1 + int'($urandom % 16);
      d   = 16'($urandom);
      eof = ($urandom % 3) == 0;
      rd  = ($urandom % 4) != 0;
      word(d, len, eof, rd);
    end
    summary();
  end
endmodule